// File: doc/BRIEF.md
# Pulse Blanking and Sampling Sequencer

This block sits between an external trigger line and the light source's power regulator. It turns the trigger into a qualified emission gate. A trigger is first conditioned for polarity and filtered for glitches. It is then checked against a minimum width and a minimum spacing between pulses. Emission is allowed only while the safety permit and the shutter-open confirmation are both present.

Around every gate transition the block opens a blanking window, so that the regulator ignores edge transients. In the stable stretch after blanking it issues a single sample strobe and holds an update-enable for the regulator. A saturation flag from the sensing chain freezes updates until the pulse and its trailing blanking are over. Pulses too short to leave any sampling window are counted.

In continuous mode, blanking is turned off. While the gate is open, the update-enable and sample strobe are issued as periodic single-cycle ticks. Every duration is a cycle count supplied on configuration inputs.

Top module: `pulse_window_seq`

## Requirements
- R1: The conditioned input equals `trig_i` when `trig_active_low_i` is 0, and the inverse of `trig_i` when it is 1. A conditioned value of 1 is a request.
- R2: The debounced request changes only after the conditioned input has been sampled at a new value on N consecutive clock edges, with N = `debounce_len_i` and a value of 0 treated as 1. An input held for fewer than N edges is ignored. When the input has been active since the first sampling edge and the request is accepted, `gate_o` rises after the (N+W)-th clock edge, where W is the minimum width.
- R3: A request must stay active for W = `min_width_i` clock cycles (0 is treated as 1) before the gate opens. A request that is held for L ≥ W cycles gives a gate of exactly L−W+1 cycles. A request that ends sooner gives no gate and a one-cycle `width_err_o` pulse.
- R4: A request is rejected, and `rep_err_o` pulses for one cycle, when it is first seen fewer than `min_period_i` clock edges after the edge at which `gate_o` last rose. The rejected request gives no gate until it is released.
- R5: `gate_o` is high only if `permit_i` and `shutter_open_i` were both high at the preceding clock edge. A request that reaches its width while either input is low is refused for as long as it stays active.
- R6: If `permit_i` or `shutter_open_i` drops during a gate, `update_o` goes low in the same cycle and `gate_o` goes low after the next clock edge. The gate stays closed until the request is released and made again.
- R7: In pulsed mode (`cont_mode_i` = 0), `blank_o` is high for exactly `blank_len_i` cycles, starting in the cycle in which `gate_o` rises or falls. A length of 0 gives no blanking.
- R8: In pulsed mode, `update_o` is high in every cycle in which the gate is high and blanking is low. `sample_o` pulses once per pulse, in the first such cycle.
- R9: Once `sat_i` has been sampled high, `update_o` stays low until a clock edge at which the gate is low, blanking is low and `sat_i` is low. `update_o` is also low in any cycle in which `sat_i` is high.
- R10: In pulsed mode, a pulse that ends without a sample raises `short_cnt_o` by one, saturating at its maximum value, in the second cycle after `gate_o` falls.
- R11: In continuous mode, no blanking is produced. While the gate is high, `update_o` and `sample_o` pulse for one cycle every I = `cont_interval_i` cycles (0 is treated as 1), the first time in the I-th gate cycle.
- R12: While reset is held, and right after it is released, `gate_o`, `blank_o`, `sample_o`, `update_o`, `width_err_o` and `rep_err_o` are 0 and `short_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | External gate/trigger line |
| trig_active_low_i | input | 1 | 1 selects an active-low trigger |
| cont_mode_i | input | 1 | 1 selects continuous mode |
| permit_i | input | 1 | Emission permit from the safety logic |
| shutter_open_i | input | 1 | Shutter-open confirmation |
| sat_i | input | 1 | Sensing-chain saturation flag |
| debounce_len_i | input | CNT_W | Debounce length in cycles |
| min_width_i | input | CNT_W | Minimum request width in cycles |
| min_period_i | input | CNT_W | Minimum spacing between gate starts in cycles |
| blank_len_i | input | CNT_W | Blanking length in cycles |
| cont_interval_i | input | CNT_W | Update interval in continuous mode |
| gate_o | output | 1 | Qualified emission gate |
| blank_o | output | 1 | Blanking window |
| sample_o | output | 1 | Sample strobe |
| update_o | output | 1 | Regulator update-enable |
| width_err_o | output | 1 | One-cycle pulse when a request is too short |
| rep_err_o | output | 1 | One-cycle pulse when a request comes too soon |
| short_cnt_o | output | SHORT_W | Count of pulses that ended without a sample |

## Verification
The gate rises N+W edges after the first edge that samples the input. It falls N+1 edges after the first edge that samples the input released. Blanking starts in the same cycle as either gate transition and covers the set number of cycles. The strobe and update-enable are combinational, so a drop of the permit or a rise of saturation affects them in the cycle it happens. The directed tests drive inputs on the falling edge and count rising edges up to these points. They sample just after the falling edge that follows the edge at which each result is due, and allow one time unit after a drive when the result is combinational. The vector loop checks results that do not depend on the exact cycle: gate length, number of update cycles, number of strobes and error pulses. It counts these at falling edges over a window long enough for the trailing blanking to finish.

// File: rtl/pws_pkg.sv
package pws_pkg;

  // Request qualifier states
  typedef enum logic [1:0] {
    QS_IDLE    = 2'd0,
    QS_ARM     = 2'd1,
    QS_GATE    = 2'd2,
    QS_HOLDOFF = 2'd3
  } qual_state_e;

endpackage

// File: rtl/pws_debounce.sv
module pws_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             level_o
);

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W:0]   ONE_W = (CNT_W+1)'(1);

  logic             cond;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   eff_len;
  logic [CNT_W:0]   cnt_next;

  assign cond     = raw_i ^ inv_i;
  assign eff_len  = (len_i == '0) ? ONE_W : {1'b0, len_i};
  assign cnt_next = {1'b0, cnt_q} + ONE_W;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (cond != lvl_q) begin
      if (cnt_next >= eff_len) begin
        lvl_d = cond;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level_o = lvl_q;

  AST_DB_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> (level_o == $past(cond))); // R2

endmodule

// File: rtl/pws_gate_qual.sv
module pws_gate_qual
  import pws_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             allow_i,
  input  logic [CNT_W-1:0] min_w_i,
  input  logic [CNT_W-1:0] min_per_i,
  output logic             gate_o,
  output logic             width_err_o,
  output logic             rep_err_o
);

  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W:0]   ONE_W     = (CNT_W+1)'(1);
  localparam logic [CNT_W-1:0] SINCE_MAX = '1;

  qual_state_e      state_q, state_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic [CNT_W-1:0] since_q, since_d;
  logic             seen_q, seen_d;
  logic             werr_q, werr_d;
  logic             rerr_q, rerr_d;
  logic             too_soon;
  logic             width_met;

  assign too_soon  = seen_q && (since_q < min_per_i);
  assign width_met = ({1'b0, wcnt_q} + ONE_W) >= {1'b0, min_w_i};

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    since_d = (since_q == SINCE_MAX) ? since_q : since_q + ONE;
    seen_d  = seen_q;
    werr_d  = 1'b0;
    rerr_d  = 1'b0;
    unique case (state_q)
      QS_IDLE: begin
        if (req_i) begin
          if (too_soon) begin
            state_d = QS_HOLDOFF;
            rerr_d  = 1'b1;
          end else if (min_w_i <= ONE) begin
            if (allow_i) begin
              state_d = QS_GATE;
              since_d = ONE;
              seen_d  = 1'b1;
            end else begin
              state_d = QS_HOLDOFF;
            end
          end else begin
            state_d = QS_ARM;
            wcnt_d  = ONE;
          end
        end
      end
      QS_ARM: begin
        if (!req_i) begin
          state_d = QS_IDLE;
          werr_d  = 1'b1;
        end else if (width_met) begin
          if (allow_i) begin
            state_d = QS_GATE;
            since_d = ONE;
            seen_d  = 1'b1;
          end else begin
            state_d = QS_HOLDOFF;
          end
        end else begin
          wcnt_d = wcnt_q + ONE;
        end
      end
      QS_GATE: begin
        if (!allow_i) begin
          state_d = QS_HOLDOFF;
        end else if (!req_i) begin
          state_d = QS_IDLE;
        end
      end
      QS_HOLDOFF: begin
        if (!req_i) begin
          state_d = QS_IDLE;
        end
      end
      default: state_d = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      wcnt_q  <= '0;
      since_q <= '0;
      seen_q  <= 1'b0;
      werr_q  <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      since_q <= since_d;
      seen_q  <= seen_d;
      werr_q  <= werr_d;
      rerr_q  <= rerr_d;
    end
  end

  assign gate_o      = (state_q == QS_GATE);
  assign width_err_o = werr_q;
  assign rep_err_o   = rerr_q;

  AST_GATE_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> $past(allow_i)); // R5
  AST_GATE_RISE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(req_i)); // R3
  AST_ALLOW_DROP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !allow_i) |=> !gate_o); // R6
  AST_REP_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_err_o |=> !rep_err_o); // R4

endmodule

// File: rtl/pws_window.sv
module pws_window #(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_i,
  input  logic               allow_i,
  input  logic               sat_i,
  input  logic               cont_i,
  input  logic [CNT_W-1:0]   blank_len_i,
  input  logic [CNT_W-1:0]   interval_i,
  output logic               blank_o,
  output logic               sample_o,
  output logic               update_o,
  output logic [SHORT_W-1:0] short_cnt_o
);

  localparam logic [CNT_W-1:0]   ONE       = CNT_W'(1);
  localparam logic [CNT_W:0]     ONE_W     = (CNT_W+1)'(1);
  localparam logic [SHORT_W-1:0] S_ONE     = SHORT_W'(1);
  localparam logic [SHORT_W-1:0] SHORT_MAX = '1;

  logic               gate_d_q;
  logic [CNT_W-1:0]   bcnt_q, bcnt_d;
  logic               sampled_q, sampled_d;
  logic               hold_q, hold_d;
  logic [CNT_W-1:0]   icnt_q, icnt_d;
  logic [SHORT_W-1:0] short_q;
  logic               short_en;

  logic               rise, fall, edge_evt;
  logic               win, pulse_smp;
  logic               tick;
  logic [CNT_W:0]     eff_int;

  assign rise     = gate_i & ~gate_d_q;
  assign fall     = ~gate_i & gate_d_q;
  assign edge_evt = (rise | fall) & ~cont_i & (blank_len_i != '0);
  assign blank_o  = ~cont_i & (edge_evt | (bcnt_q != '0));

  // pulsed mode: stable window after blanking
  assign win       = gate_i & ~blank_o & allow_i & ~cont_i;
  assign pulse_smp = win & (rise | ~sampled_q);

  // continuous mode: periodic tick
  assign eff_int = (interval_i == '0) ? ONE_W : {1'b0, interval_i};
  assign tick    = cont_i & gate_i & (({1'b0, icnt_q} + ONE_W) >= eff_int);

  assign sample_o = pulse_smp | (tick & allow_i);
  assign update_o = (win | (tick & allow_i)) & ~hold_q & ~sat_i;

  always_comb begin
    if (edge_evt) begin
      bcnt_d = blank_len_i - ONE;
    end else if (bcnt_q != '0) begin
      bcnt_d = bcnt_q - ONE;
    end else begin
      bcnt_d = '0;
    end

    if (pulse_smp) begin
      sampled_d = 1'b1;
    end else if (rise) begin
      sampled_d = 1'b0;
    end else begin
      sampled_d = sampled_q;
    end

    if (sat_i) begin
      hold_d = 1'b1;
    end else if (!gate_i && !blank_o) begin
      hold_d = 1'b0;
    end else begin
      hold_d = hold_q;
    end

    if (!gate_i || tick) begin
      icnt_d = '0;
    end else begin
      icnt_d = icnt_q + ONE;
    end

    short_en = fall & ~cont_i & ~sampled_q & (short_q != SHORT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d_q  <= 1'b0;
      bcnt_q    <= '0;
      sampled_q <= 1'b0;
      hold_q    <= 1'b0;
      icnt_q    <= '0;
    end else begin
      gate_d_q  <= gate_i;
      bcnt_q    <= bcnt_d;
      sampled_q <= sampled_d;
      hold_q    <= hold_d;
      icnt_q    <= icnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= '0;
    end else if (short_en) begin
      short_q <= short_q + S_ONE;
    end
  end

  assign short_cnt_o = short_q;

  AST_NO_UPD_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> !blank_o); // R7
  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sat_i) && gate_i) |-> !update_o); // R9
  AST_SHORT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (short_cnt_o != $past(short_cnt_o)) |-> (short_cnt_o == $past(short_cnt_o) + S_ONE)); // R10
  AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !cont_i) |=> (!sample_o || cont_i)); // R8

endmodule

// File: rtl/pulse_window_seq.sv
module pulse_window_seq #(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic               trig_active_low_i,
  input  logic               cont_mode_i,
  input  logic               permit_i,
  input  logic               shutter_open_i,
  input  logic               sat_i,
  input  logic [CNT_W-1:0]   debounce_len_i,
  input  logic [CNT_W-1:0]   min_width_i,
  input  logic [CNT_W-1:0]   min_period_i,
  input  logic [CNT_W-1:0]   blank_len_i,
  input  logic [CNT_W-1:0]   cont_interval_i,
  output logic               gate_o,
  output logic               blank_o,
  output logic               sample_o,
  output logic               update_o,
  output logic               width_err_o,
  output logic               rep_err_o,
  output logic [SHORT_W-1:0] short_cnt_o
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       allow;
  logic       req;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign allow = permit_i & shutter_open_i;

  pws_debounce #(.CNT_W(CNT_W)) i_debounce (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .raw_i   (trig_i),
    .inv_i   (trig_active_low_i),
    .len_i   (debounce_len_i),
    .level_o (req)
  );

  pws_gate_qual #(.CNT_W(CNT_W)) i_gate_qual (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .req_i       (req),
    .allow_i     (allow),
    .min_w_i     (min_width_i),
    .min_per_i   (min_period_i),
    .gate_o      (gate_o),
    .width_err_o (width_err_o),
    .rep_err_o   (rep_err_o)
  );

  pws_window #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) i_window (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .gate_i      (gate_o),
    .allow_i     (allow),
    .sat_i       (sat_i),
    .cont_i      (cont_mode_i),
    .blank_len_i (blank_len_i),
    .interval_i  (cont_interval_i),
    .blank_o     (blank_o),
    .sample_o    (sample_o),
    .update_o    (update_o),
    .short_cnt_o (short_cnt_o)
  );

  AST_UPD_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_core_n)
    update_o |-> (gate_o && permit_i && shutter_open_i)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_core_n |-> (!gate_o && !width_err_o && !rep_err_o)); // R12

endmodule

// File: tb/test_pulse_window_seq.sv
`timescale 1ns/1ps
module test_pulse_window_seq;

  localparam int CNT_W   = 16;
  localparam int SHORT_W = 8;

  logic               clk;
  logic               rst_n;
  logic               trig_i;
  logic               trig_active_low_i;
  logic               cont_mode_i;
  logic               permit_i;
  logic               shutter_open_i;
  logic               sat_i;
  logic [CNT_W-1:0]   debounce_len_i;
  logic [CNT_W-1:0]   min_width_i;
  logic [CNT_W-1:0]   min_period_i;
  logic [CNT_W-1:0]   blank_len_i;
  logic [CNT_W-1:0]   cont_interval_i;
  logic               gate_o;
  logic               blank_o;
  logic               sample_o;
  logic               update_o;
  logic               width_err_o;
  logic               rep_err_o;
  logic [SHORT_W-1:0] short_cnt_o;

  pulse_window_seq #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) i_pulse_window_seq (
    .clk               (clk),
    .rst_n             (rst_n),
    .trig_i            (trig_i),
    .trig_active_low_i (trig_active_low_i),
    .cont_mode_i       (cont_mode_i),
    .permit_i          (permit_i),
    .shutter_open_i    (shutter_open_i),
    .sat_i             (sat_i),
    .debounce_len_i    (debounce_len_i),
    .min_width_i       (min_width_i),
    .min_period_i      (min_period_i),
    .blank_len_i       (blank_len_i),
    .cont_interval_i   (cont_interval_i),
    .gate_o            (gate_o),
    .blank_o           (blank_o),
    .sample_o          (sample_o),
    .update_o          (update_o),
    .width_err_o       (width_err_o),
    .rep_err_o         (rep_err_o),
    .short_cnt_o       (short_cnt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // running counts of output activity, sampled at falling edges
  int n_gate = 0, n_blank = 0, n_smp = 0, n_upd = 0, n_werr = 0, n_rerr = 0;
  always @(negedge clk) begin
    n_gate  += int'(gate_o);
    n_blank += int'(blank_o);
    n_smp   += int'(sample_o);
    n_upd   += int'(update_o);
    n_werr  += int'(width_err_o);
    n_rerr  += int'(rep_err_o);
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // stimulus and expected results: gate cycles and width error
  typedef struct packed {
    logic       pol;
    logic [3:0] n;
    logic [3:0] w;
    logic [5:0] len;
    logic       permit;
    logic       shutter;
    logic [5:0] exp_gate;
    logic       exp_werr;
  } vec_t;

  localparam int NV = 8;
  localparam int BLANK = 2;
  localparam vec_t VEC [NV] = '{
    '{pol:1'b0, n:4'd1, w:4'd1, len:6'd5, permit:1'b1, shutter:1'b1, exp_gate:6'd5, exp_werr:1'b0},
    '{pol:1'b1, n:4'd2, w:4'd3, len:6'd6, permit:1'b1, shutter:1'b1, exp_gate:6'd4, exp_werr:1'b0},
    '{pol:1'b0, n:4'd3, w:4'd4, len:6'd3, permit:1'b1, shutter:1'b1, exp_gate:6'd0, exp_werr:1'b1},
    '{pol:1'b0, n:4'd3, w:4'd1, len:6'd1, permit:1'b1, shutter:1'b1, exp_gate:6'd0, exp_werr:1'b0},
    '{pol:1'b1, n:4'd1, w:4'd2, len:6'd8, permit:1'b1, shutter:1'b0, exp_gate:6'd0, exp_werr:1'b0},
    '{pol:1'b0, n:4'd2, w:4'd2, len:6'd7, permit:1'b0, shutter:1'b1, exp_gate:6'd0, exp_werr:1'b0},
    '{pol:1'b0, n:4'd4, w:4'd2, len:6'd9, permit:1'b1, shutter:1'b1, exp_gate:6'd8, exp_werr:1'b0},
    '{pol:1'b1, n:4'd1, w:4'd5, len:6'd6, permit:1'b1, shutter:1'b1, exp_gate:6'd2, exp_werr:1'b0}
  };

  int exp_short = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R12 actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    trig_i = 1'b0; trig_active_low_i = 1'b0; cont_mode_i = 1'b0;
    permit_i = 1'b1; shutter_open_i = 1'b1; sat_i = 1'b0;
    debounce_len_i = 16'd1; min_width_i = 16'd1; min_period_i = 16'd0;
    blank_len_i = 16'(BLANK); cont_interval_i = 16'd4;
    repeat (3) @(negedge clk);
    chk("R12 gate in reset", int'(gate_o), 0);
    chk("R12 short count in reset", int'(short_cnt_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 gate after reset", int'(gate_o), 0);
    chk("R12 strobes after reset", int'({blank_o, sample_o, update_o, width_err_o, rep_err_o}), 0);

    // vector loop
    for (int i = 0; i < NV; i++) begin
      int g0, b0, s0, u0, w0;
      int eg, eu, es;
      string tag;
      trig_active_low_i = VEC[i].pol;
      trig_i            = VEC[i].pol;
      debounce_len_i    = 16'(VEC[i].n);
      min_width_i       = 16'(VEC[i].w);
      permit_i          = VEC[i].permit;
      shutter_open_i    = VEC[i].shutter;
      repeat (5) @(negedge clk);
      g0 = n_gate; s0 = n_smp; u0 = n_upd; w0 = n_werr; b0 = n_blank;
      trig_i = ~VEC[i].pol;
      repeat (int'(VEC[i].len)) @(negedge clk);
      trig_i = VEC[i].pol;
      repeat (30) @(negedge clk);
      eg = int'(VEC[i].exp_gate);
      eu = (eg > BLANK) ? eg - BLANK : 0;
      es = (eg > BLANK) ? 1 : 0;
      if (eg > 0 && eg <= BLANK) exp_short++;
      if (!VEC[i].permit || !VEC[i].shutter) tag = "R5 refused gate";
      else if (VEC[i].len < VEC[i].n) tag = "R2 glitch filtered";
      else if (VEC[i].pol) tag = "R1 inverted input gate";
      else tag = "R3 gate width";
      chk(tag, n_gate - g0, eg);
      chk("R3 width_err pulses", n_werr - w0, int'(VEC[i].exp_werr));
      chk("R8 update cycles", n_upd - u0, eu);
      chk("R8 sample strobes", n_smp - s0, es);
      chk("R7 blank cycles", n_blank - b0, (eg > 0) ? 2 * BLANK : 0);
    end
    chk("R10 short count after vectors", int'(short_cnt_o), exp_short);

    // directed: exact latency, blanking, window, saturation hold
    trig_active_low_i = 1'b0; trig_i = 1'b0;
    permit_i = 1'b1; shutter_open_i = 1'b1;
    debounce_len_i = 16'd3; min_width_i = 16'd2; blank_len_i = 16'd2;
    repeat (5) @(negedge clk);
    trig_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 gate not yet open", int'(gate_o), 0);
    @(negedge clk);
    chk("R2 gate open after N+W edges", int'(gate_o), 1);
    chk("R7 blank in rise cycle", int'(blank_o), 1);
    chk("R8 no update in blank", int'(update_o), 0);
    @(negedge clk);
    chk("R7 blank second cycle", int'(blank_o), 1);
    @(negedge clk);
    chk("R7 blank ended", int'(blank_o), 0);
    chk("R8 sample strobe first window cycle", int'(sample_o), 1);
    chk("R8 update in window", int'(update_o), 1);
    @(negedge clk);
    chk("R8 single sample strobe", int'(sample_o), 0);
    chk("R8 update continues", int'(update_o), 1);
    sat_i = 1'b1;
    #1;
    chk("R9 update off while saturated", int'(update_o), 0);
    @(negedge clk);
    sat_i = 1'b0;
    #1;
    chk("R9 update held after saturation", int'(update_o), 0);
    chk("R9 gate still open", int'(gate_o), 1);
    @(negedge clk);
    trig_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 update held to pulse end", int'(update_o), 0);
    chk("R2 gate open before release latency", int'(gate_o), 1);
    @(negedge clk);
    chk("R2 gate closed after release", int'(gate_o), 0);
    chk("R7 blank on falling gate", int'(blank_o), 1);
    @(negedge clk);
    chk("R7 trailing blank second cycle", int'(blank_o), 1);
    @(negedge clk);
    chk("R7 trailing blank ended", int'(blank_o), 0);
    repeat (8) @(negedge clk);

    // hold released on next pulse, then permit drop
    trig_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 hold released on new pulse", int'(update_o), 1);
    permit_i = 1'b0;
    #1;
    chk("R6 update off on permit drop", int'(update_o), 0);
    @(negedge clk);
    chk("R6 gate closed after permit drop", int'(gate_o), 0);
    permit_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 gate stays closed until re-request", int'(gate_o), 0);
    trig_i = 1'b0;
    repeat (12) @(negedge clk);

    // minimum repetition period
    begin
      int g0, r0;
      debounce_len_i = 16'd1; min_width_i = 16'd2; min_period_i = 16'd30;
      repeat (40) @(negedge clk);
      g0 = n_gate; r0 = n_rerr;
      trig_i = 1'b1; repeat (6) @(negedge clk);
      trig_i = 1'b0; repeat (5) @(negedge clk);
      trig_i = 1'b1; repeat (6) @(negedge clk);
      trig_i = 1'b0; repeat (10) @(negedge clk);
      chk("R4 early request rejected", n_gate - g0, 5);
      chk("R4 rep_err single pulse", n_rerr - r0, 1);
      repeat (40) @(negedge clk);
      g0 = n_gate; r0 = n_rerr;
      trig_i = 1'b1; repeat (6) @(negedge clk);
      trig_i = 1'b0; repeat (10) @(negedge clk);
      chk("R4 spaced request accepted", n_gate - g0, 5);
      chk("R4 no rep_err when spaced", n_rerr - r0, 0);
      min_period_i = 16'd0;
    end

    // continuous mode
    begin
      int g0, b0, s0, u0;
      cont_mode_i = 1'b1; min_width_i = 16'd1; cont_interval_i = 16'd4;
      repeat (5) @(negedge clk);
      g0 = n_gate; b0 = n_blank; s0 = n_smp; u0 = n_upd;
      trig_i = 1'b1; repeat (20) @(negedge clk);
      trig_i = 1'b0; repeat (10) @(negedge clk);
      chk("R11 gate cycles", n_gate - g0, 20);
      chk("R11 periodic updates", n_upd - u0, 5);
      chk("R11 periodic samples", n_smp - s0, 5);
      chk("R11 no blanking", n_blank - b0, 0);
      cont_mode_i = 1'b0;
    end
    chk("R10 short count final", int'(short_cnt_o), exp_short);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule